// File: doc/BRIEF.md
# Serial configuration slave for a clock buffer

The block is a two-wire serial-bus slave that holds the six 8-bit control bytes of a clock buffer and drives them out in parallel. A host moves data with block transfers only. A write carries a command byte and a count byte, which the slave acknowledges and throws away, and then data bytes that fill the registers from byte 0 upward. A read returns a count byte first and then the register contents.

SCL and SDA are brought into a fast system clock through a two-flop synchronizer. Start and stop conditions are found as SDA edges while SCL is high. The slave pulls SDA low through an open-drain enable, to acknowledge a byte or to send a 0 bit. It never stretches the clock.

Top module: `clkbuf_cfg_slave`

## Requirements
- R1: The slave acknowledges only the address bytes 0xD2 (write) and 0xD3 (read). Any other address gets no acknowledge, and every later byte of that transfer is left unacknowledged until the next start.
- R2: In a write, the two bytes after the address (command, then count) are both acknowledged, and neither changes any register.
- R3: Write data bytes, received MSB first, load byte 0, byte 1, ... byte 5 in order. Each one is acknowledged. Byte k appears on cfg_o[8k+7:8k].
- R4: A read sends the count value 0x06 first and then bytes 0 to 5 in order, MSB first. A 0 bit is sent by asserting sda_oe_o.
- R5: After reset the bytes are 0xFF, 0xC0, 0xFF, 0xFF, 0xFF and 0x06, for bytes 0 to 5 in that order.
- R6: A stop may end a write after any complete byte. Bytes that were not reached keep their values, and cfg_o changes only when a data byte completes.
- R7: Data bytes past byte 5 are acknowledged but not stored.
- R8: A stop or a repeated start in the middle of a byte drops that byte and leaves every register unchanged. A repeated start begins a new address byte.
- R9: When the master does not acknowledge a read byte, the slave releases SDA and sends nothing more until the next start.
- R10: The slave changes sda_oe_o only while the synchronized SCL is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock, at least 20 times the SCL rate |
| rst_ni | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Serial clock from the bus |
| sda_i | input | 1 | Serial data as seen on the bus |
| sda_oe_o | output | 1 | 1 pulls SDA low (open-drain drive) |
| cfg_o | output | 48 | Register bytes; byte k on bits 8k+7:8k |

## Verification
The bench builds the block with its defaults: six register bytes, addresses 0xD2/0xD3, two synchronizer stages. It runs SCL at 1/50 of the system clock, so each bus phase spans many synchronizer delays and the register update falls well inside a bit time. Six bytes are few enough to send past the last one, to stop after a partial write, and to abort in the middle of a byte with both a stop and a repeated start. A reference image of the six bytes is compared with cfg_o on every clock.

// File: rtl/cfgs_pkg.sv
package cfgs_pkg;
  typedef enum logic [2:0] {
    ST_IDLE, ST_ADDR, ST_CMD, ST_CNT, ST_WDATA, ST_RDATA, ST_SKIP
  } phase_e;

  localparam int unsigned DEF_BYTES = 6;
  localparam logic [DEF_BYTES*8-1:0] DEF_RESET = 48'h06_FF_FF_FF_C0_FF;
endpackage

// File: rtl/cfgs_bus_sync.sv
module cfgs_bus_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_s_o,
  output logic sda_s_o,
  output logic start_o,
  output logic stop_o,
  output logic rise_o,
  output logic fall_o
);
  logic [STAGES-1:0] scl_ff, sda_ff;
  logic scl_d, sda_d;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      scl_ff <= '1;
      sda_ff <= '1;
      scl_d  <= 1'b1;
      sda_d  <= 1'b1;
    end else begin
      scl_ff <= {scl_ff[STAGES-2:0], scl_i};
      sda_ff <= {sda_ff[STAGES-2:0], sda_i};
      scl_d  <= scl_ff[STAGES-1];
      sda_d  <= sda_ff[STAGES-1];
    end
  end

  assign scl_s_o = scl_ff[STAGES-1];
  assign sda_s_o = sda_ff[STAGES-1];
  assign start_o = scl_s_o & scl_d & sda_d & ~sda_s_o;
  assign stop_o  = scl_s_o & scl_d & ~sda_d & sda_s_o;
  assign rise_o  = scl_s_o & ~scl_d;
  assign fall_o  = ~scl_s_o & scl_d;
endmodule

// File: rtl/cfgs_xfer_fsm.sv
module cfgs_xfer_fsm
  import cfgs_pkg::*;
#(
  parameter int unsigned NUM_BYTES = 6,
  parameter logic [7:0]  WR_ADDR   = 8'hD2,
  parameter logic [7:0]  RD_ADDR   = 8'hD3,
  localparam int unsigned PW = $clog2(NUM_BYTES + 2)
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   scl_s_i,
  input  logic                   sda_s_i,
  input  logic                   start_i,
  input  logic                   stop_i,
  input  logic                   rise_i,
  input  logic                   fall_i,
  input  logic [NUM_BYTES*8-1:0] cfg_i,
  output logic                   sda_oe_o,
  output logic                   wr_en_o,
  output logic [PW-1:0]          wr_idx_o,
  output logic [7:0]             wr_data_o
);
  phase_e      state_q, nxt_q;
  logic [3:0]  cnt_q;
  logic [7:0]  shreg_q, tx_q, tx_next;
  logic [PW-1:0] ptr_q;
  logic        sda_oe_q, mack_q, wr_en_q;
  logic [PW-1:0] wr_idx_q;
  logic [7:0]  wr_data_q;
  logic        active;

  // ptr 0 selects the count byte, 1..N the registers, beyond that all ones
  always_comb begin
    tx_next = 8'hFF;
    if (ptr_q == '0) tx_next = 8'(NUM_BYTES);
    else if (int'(ptr_q) <= int'(NUM_BYTES)) tx_next = cfg_i[(int'(ptr_q)-1)*8 +: 8];
  end

  assign active = (state_q != ST_IDLE) && (state_q != ST_SKIP);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q   <= ST_IDLE;
      nxt_q     <= ST_IDLE;
      cnt_q     <= '0;
      shreg_q   <= '0;
      tx_q      <= '1;
      ptr_q     <= '0;
      sda_oe_q  <= 1'b0;
      mack_q    <= 1'b0;
      wr_en_q   <= 1'b0;
      wr_idx_q  <= '0;
      wr_data_q <= '0;
    end else begin
      wr_en_q <= 1'b0;
      if (start_i) begin
        state_q  <= ST_ADDR;
        cnt_q    <= '0;
        sda_oe_q <= 1'b0;
      end else if (stop_i) begin
        state_q  <= ST_IDLE;
        cnt_q    <= '0;
        sda_oe_q <= 1'b0;
      end else if (active && rise_i) begin
        if (cnt_q < 4'd8) begin
          if (state_q != ST_RDATA) shreg_q <= {shreg_q[6:0], sda_s_i};
          cnt_q <= cnt_q + 4'd1;
        end else if (cnt_q == 4'd8) begin
          cnt_q <= 4'd9;
          if (state_q == ST_RDATA) mack_q <= ~sda_s_i;
        end
      end else if (active && fall_i) begin
        if (state_q == ST_RDATA && cnt_q >= 4'd1 && cnt_q <= 4'd7) begin
          tx_q     <= {tx_q[6:0], 1'b1};
          sda_oe_q <= ~tx_q[6];
        end else if (cnt_q == 4'd8) begin
          if (state_q == ST_RDATA) begin
            sda_oe_q <= 1'b0;
          end else begin
            sda_oe_q <= 1'b1;
            unique case (state_q)
              ST_ADDR: begin
                ptr_q <= '0;
                if (shreg_q == WR_ADDR)      nxt_q <= ST_CMD;
                else if (shreg_q == RD_ADDR) nxt_q <= ST_RDATA;
                else begin
                  nxt_q    <= ST_SKIP;
                  sda_oe_q <= 1'b0;
                end
              end
              ST_CMD: nxt_q <= ST_CNT;
              ST_CNT: begin
                nxt_q <= ST_WDATA;
                ptr_q <= '0;
              end
              default: begin
                nxt_q <= ST_WDATA;
                if (int'(ptr_q) < int'(NUM_BYTES)) begin
                  wr_en_q   <= 1'b1;
                  wr_idx_q  <= ptr_q;
                  wr_data_q <= shreg_q;
                  ptr_q     <= ptr_q + PW'(1);
                end
              end
            endcase
          end
        end else if (cnt_q == 4'd9) begin
          cnt_q    <= '0;
          sda_oe_q <= 1'b0;
          if (state_q == ST_RDATA && !mack_q) begin
            state_q <= ST_SKIP;
          end else begin
            state_q <= (state_q == ST_RDATA) ? ST_RDATA : nxt_q;
            if (state_q == ST_RDATA || nxt_q == ST_RDATA) begin
              tx_q     <= tx_next;
              sda_oe_q <= ~tx_next[7];
              if (int'(ptr_q) <= int'(NUM_BYTES)) ptr_q <= ptr_q + PW'(1);
            end
          end
        end
      end
    end
  end

  assign sda_oe_o  = sda_oe_q;
  assign wr_en_o   = wr_en_q;
  assign wr_idx_o  = wr_idx_q;
  assign wr_data_o = wr_data_q;

  // R10
  sda_low_phase_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(sda_oe_q) |-> !scl_s_i);
  // R1
  idle_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_IDLE || state_q == ST_SKIP) |-> !sda_oe_q);
  // R8
  restart_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i |=> (state_q == ST_ADDR && cnt_q == 4'd0));
endmodule

// File: rtl/cfgs_regs.sv
module cfgs_regs #(
  parameter int unsigned NUM_BYTES = 6,
  parameter logic [NUM_BYTES*8-1:0] RESET_VAL = '1,
  localparam int unsigned PW = $clog2(NUM_BYTES + 2)
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   wr_en_i,
  input  logic [PW-1:0]          idx_i,
  input  logic [7:0]             data_i,
  output logic [NUM_BYTES*8-1:0] cfg_o
);
  for (genvar g = 0; g < NUM_BYTES; g++) begin : g_byte
    logic [7:0] byte_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                              byte_q <= RESET_VAL[g*8 +: 8];
      else if (wr_en_i && idx_i == PW'(g))      byte_q <= data_i;
    end
    assign cfg_o[g*8 +: 8] = byte_q;
  end

  // R7
  wr_range_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_i |-> (int'(idx_i) < int'(NUM_BYTES)));
  // R6
  hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(cfg_o) |-> $past(wr_en_i));
endmodule

// File: rtl/clkbuf_cfg_slave.sv
module clkbuf_cfg_slave #(
  parameter int unsigned NUM_BYTES   = cfgs_pkg::DEF_BYTES,
  parameter int unsigned SYNC_STAGES = 2,
  parameter logic [7:0]  WR_ADDR     = 8'hD2,
  parameter logic [7:0]  RD_ADDR     = 8'hD3,
  parameter logic [NUM_BYTES*8-1:0] RESET_VAL = cfgs_pkg::DEF_RESET
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   scl_i,
  input  logic                   sda_i,
  output logic                   sda_oe_o,
  output logic [NUM_BYTES*8-1:0] cfg_o
);
  localparam int unsigned PW = $clog2(NUM_BYTES + 2);

  logic scl_s, sda_s, start, stop, rise, fall;
  logic wr_en;
  logic [PW-1:0] wr_idx;
  logic [7:0] wr_data;

  cfgs_bus_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk_i, .rst_ni, .scl_i, .sda_i,
    .scl_s_o(scl_s), .sda_s_o(sda_s), .start_o(start), .stop_o(stop),
    .rise_o(rise), .fall_o(fall)
  );

  cfgs_xfer_fsm #(.NUM_BYTES(NUM_BYTES), .WR_ADDR(WR_ADDR), .RD_ADDR(RD_ADDR)) u_fsm (
    .clk_i, .rst_ni, .scl_s_i(scl_s), .sda_s_i(sda_s), .start_i(start), .stop_i(stop),
    .rise_i(rise), .fall_i(fall), .cfg_i(cfg_o), .sda_oe_o,
    .wr_en_o(wr_en), .wr_idx_o(wr_idx), .wr_data_o(wr_data)
  );

  cfgs_regs #(.NUM_BYTES(NUM_BYTES), .RESET_VAL(RESET_VAL)) u_regs (
    .clk_i, .rst_ni, .wr_en_i(wr_en), .idx_i(wr_idx), .data_i(wr_data), .cfg_o
  );
endmodule

// File: tb/tb_clkbuf_cfg_slave.sv
module tb_clkbuf_cfg_slave;
  localparam int N = 6;
  localparam int Q = 12;
  localparam int H = 25;

  logic clk = 1'b0, rst_n = 1'b1, scl = 1'b1, m_sda = 1'b1;
  logic sda_oe, sda_bus;
  logic [N*8-1:0] cfg;
  int checks = 0, failures = 0;
  bit cmp_en = 1'b0;
  logic [7:0] model [N];

  assign sda_bus = m_sda & ~sda_oe;
  always #5 clk = ~clk;

  clkbuf_cfg_slave dut (
    .clk_i(clk), .rst_ni(rst_n), .scl_i(scl), .sda_i(sda_bus),
    .sda_oe_o(sda_oe), .cfg_o(cfg)
  );

  function automatic logic [N*8-1:0] model_vec();
    logic [N*8-1:0] v;
    for (int k = 0; k < N; k++) v[k*8 +: 8] = model[k];
    return v;
  endfunction

  // reference register image against the outputs on every clock (R3, R6)
  always @(negedge clk) begin
    if (cmp_en) begin
      checks++;
      if (cfg !== model_vec()) begin
        failures++;
        $display("FAIL R6 image actual=%h expected=%h", cfg, model_vec());
      end
    end
  end

  task automatic wt(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic bus_start();
    m_sda = 1'b1; wt(Q); scl = 1'b1; wt(Q);
    m_sda = 1'b0; wt(H); scl = 1'b0; wt(Q);
  endtask

  task automatic bus_stop();
    m_sda = 1'b0; wt(Q); scl = 1'b1; wt(Q);
    m_sda = 1'b1; wt(H);
  endtask

  task automatic send_bits(input logic [7:0] b, input int nb);
    for (int i = 7; i > 7 - nb; i--) begin
      m_sda = b[i]; wt(Q); scl = 1'b1; wt(H); scl = 1'b0; wt(Q);
    end
  endtask

  task automatic wr_byte(input logic [7:0] b, input bit exp_ack, input int midx, input string tag);
    for (int i = 7; i >= 0; i--) begin
      m_sda = b[i]; wt(Q); scl = 1'b1; wt(H);
      if (i == 0) begin
        cmp_en = 1'b0;
        if (midx >= 0 && midx < N) model[midx] = b;
      end
      scl = 1'b0; wt(Q);
    end
    m_sda = 1'b1; wt(Q); scl = 1'b1; wt(Q);
    chk((sda_bus == 1'b0) == exp_ack, tag, 64'(sda_bus), 64'(!exp_ack));
    wt(H - Q); scl = 1'b0; wt(Q);
    cmp_en = 1'b1;
  endtask

  task automatic rd_byte(output logic [7:0] got, input bit mack);
    m_sda = 1'b1;
    for (int i = 7; i >= 0; i--) begin
      wt(Q); scl = 1'b1; wt(Q); got[i] = sda_bus; wt(H - Q); scl = 1'b0; wt(Q);
    end
    m_sda = mack ? 1'b0 : 1'b1; wt(Q); scl = 1'b1; wt(H); scl = 1'b0; wt(Q);
    m_sda = 1'b1;
  endtask

  task automatic rd_body(input string tag);
    logic [7:0] g;
    rd_byte(g, 1'b1);
    chk(g == 8'h06, "R4 count", 64'(g), 64'h06);
    for (int k = 0; k < N; k++) begin
      rd_byte(g, k != N - 1);
      chk(g == model[k], tag, 64'(g), 64'(model[k]));
    end
    bus_stop();
  endtask

  task automatic rd_all(input string tag);
    bus_start();
    wr_byte(8'hD3, 1'b1, -1, "R1 read addr");
    rd_body(tag);
  endtask

  task automatic wr_head();
    bus_start();
    wr_byte(8'hD2, 1'b1, -1, "R1 write addr");
    wr_byte(8'h00, 1'b1, -1, "R2 command");
    wr_byte(8'h03, 1'b1, -1, "R2 count");
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    failures++;
    $display("FAIL watchdog actual=running expected=done");
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    logic [7:0] g;
    model[0] = 8'hFF; model[1] = 8'hC0; model[2] = 8'hFF;
    model[3] = 8'hFF; model[4] = 8'hFF; model[5] = 8'h06;
    #1 rst_n = 1'b0;
    wt(3);
    chk(cfg == 48'h06_FF_FF_FF_C0_FF, "R5 reset", 64'(cfg), 64'h06_FF_FF_FF_C0_FF);
    chk(sda_oe == 1'b0, "R1 reset release", 64'(sda_oe), 64'h0);
    rst_n = 1'b1;
    wt(3);
    cmp_en = 1'b1;

    // R5 / R4: defaults read back over the bus
    rd_all("R5 default readback");

    // R3: full write, then readback
    wr_head();
    for (int k = 0; k < N; k++) wr_byte(8'h11 * 8'(k + 1) ^ 8'hA5, 1'b1, k, "R3 data");
    bus_stop();
    rd_all("R3 readback");

    // R6: partial write of two bytes
    wr_head();
    wr_byte(8'h3C, 1'b1, 0, "R6 data");
    wr_byte(8'h81, 1'b1, 1, "R6 data");
    bus_stop();
    rd_all("R6 readback");

    // R7: data past the last byte acked, not stored
    wr_head();
    for (int k = 0; k < N + 2; k++) wr_byte(8'(8'h40 + k), 1'b1, k, "R7 data ack");
    bus_stop();
    rd_all("R7 readback");

    // R1: foreign address gets no ack, later bytes ignored
    bus_start();
    wr_byte(8'hA0, 1'b0, -1, "R1 foreign addr");
    wr_byte(8'h00, 1'b0, -1, "R1 ignored byte");
    wr_byte(8'h5A, 1'b0, -1, "R1 ignored byte");
    bus_stop();
    rd_all("R1 readback");

    // R8: stop in the middle of a byte
    wr_head();
    wr_byte(8'h5A, 1'b1, 0, "R8 data");
    send_bits(8'h33, 4);
    bus_stop();
    rd_all("R8 stop abort readback");

    // R8: repeated start in the middle of a byte, then read
    wr_head();
    send_bits(8'h00, 5);
    bus_start();
    wr_byte(8'hD3, 1'b1, -1, "R8 restart addr");
    rd_body("R8 restart readback");

    // R9: master nack releases SDA
    bus_start();
    wr_byte(8'hD3, 1'b1, -1, "R9 addr");
    rd_byte(g, 1'b0);
    chk(g == 8'h06, "R9 count", 64'(g), 64'h06);
    rd_byte(g, 1'b0);
    chk(g == 8'hFF, "R9 released", 64'(g), 64'hFF);
    bus_stop();

    cmp_en = 1'b0;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule